// File: doc/BRIEF.md
# Bit-Plane GPIO Port Controller

This block controls one 32-pin general-purpose I/O port. Every per-pin attribute lives in its own 32-bit bit-plane, one bit per pin. Software reaches each plane through a small word-addressed register bus. Each plane has three access slots: a direct read/write slot, a slot that sets the 1 bits of the written mask, and a slot that clears them. Multi-bit per-pin settings are split across several planes: the peripheral function code uses three planes, the drive strength two, and the edge mode two.

Each pad is owned either by the GPIO logic or by one of eight peripheral functions. The block muxes the pad output and output enable, and sends pull, slew, Schmitt and drive codes to the pad as static controls. Pad inputs pass through a two-flop synchroniser and an optional per-pin glitch filter. They then reach an edge detector that latches interrupt flags and raises one interrupt line. When a pin is owned by a peripheral and has events enabled, the detector also emits a one-cycle event pulse for that pin.

Top module: `gpio_plane_ctrl`

## Requirements
- R1: The plane index is bus_addr[6:2] and the access kind is bus_addr[1:0]. The access kinds are 0 = read/write, 1 = set the mask's 1 bits, 2 = clear the mask's 1 bits, and 3 = reads zero with writes ignored. A set or clear write leaves every bit whose mask bit is 0 unchanged. The planes are: 0 GPIO ownership, 1 output enable, 2 output value, 3 pull-up, 4 pull-down, 5/6/7 function code bits 0/1/2, 8/9 drive bits 0/1, 10 slew, 11 Schmitt, 12 glitch filter, 13 event enable, 14 interrupt enable, 15/16 mode bits 0/1, 17 interrupt flags, 18 pin value.
- R2: After reset, the ownership plane reads all ones and every other plane reads zero. This gives function A, weakest drive and mode 00 on every pin, with all flags clear.
- R3: A GPIO-owned pin drives pad_o from its output value bit. Its pad_oe is 1 only when its output enable bit is 1; otherwise the pin is tri-stated.
- R4: A pin with ownership 0 takes pad_o and pad_oe from the peripheral function selected by the code {bit 2, bit 1, bit 0}. Codes 0 to 7 select periph_o/periph_oe word 0 to 7, where word f occupies bits [32f+31:32f].
- R5: pad_drv[2i+1:2i] equals {drive bit 1, drive bit 0} of pin i. 00 is the weakest setting and 11 the strongest.
- R6: pad_pu, pad_pd, pad_slew and pad_schmitt follow their planes bit for bit.
- R7: The pin value plane (18) returns the pads through two flops. A pad change made before clock edge k is readable after edge k+1. Writes to plane 18 are ignored.
- R8: With the filter off, an accepted level change sets the pin's flag at edge k+2. Mode 00 flags both edges, 01 flags rising edges only and 10 flags falling edges only.
- R9: Mode 11 never sets a flag.
- R10: With the glitch filter on, a new synchronised level must be seen for three consecutive clocks before it is accepted. A pad pulse of two clocks is rejected. A level held for four clocks sets the flag at edge k+4.
- R11: irq_o is the OR over all pins of flag AND interrupt enable. Flags are cleared only by writing 1 bits to the clear slot of plane 17; writes to its read/write and set slots are ignored.
- R12: A pin with ownership 0 and event enable 1 pulses evt_o[i] for exactly one cycle on each accepted edge that its mode matches. A GPIO-owned pin never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Plane index and access kind |
| bus_wdata | input | 32 | Write mask or data |
| bus_rdata | output | 32 | Read data (combinational) |
| pad_i | input | 32 | Raw pad input levels |
| pad_o | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables |
| pad_pu | output | 32 | Pull-up enables |
| pad_pd | output | 32 | Pull-down enables |
| pad_slew | output | 32 | Slew control enables |
| pad_schmitt | output | 32 | Schmitt trigger enables |
| pad_drv | output | 64 | Two-bit drive code per pin |
| periph_o | input | 256 | Output levels of the eight peripheral functions |
| periph_oe | input | 256 | Output enables of the eight peripheral functions |
| evt_o | output | 32 | Per-pin event pulses |
| irq_o | output | 1 | Port interrupt |

## Verification
On every cycle, the assertions check four things. Set and clear writes touch only the masked bits of a plane. A flag bit can rise only when the edge logic reports a hit. No flag rises on a pin whose mode is 11. The glitch filter accepts only a level that the synchroniser has held for three clocks. They also check that a GPIO-owned pin without output enable never drives, and that event pulses come only from peripheral-owned pins with events enabled. The bench scenarios are needed for the exact edge-to-flag latency, the rejection of a short pulse, the per-mode edge selection, the function and drive code ordering, and the ignored writes to the flag and pin-value planes.

// File: rtl/gpio_plane_pkg.sv
package gpio_plane_pkg;
    localparam int PLANE_W = 5;
    localparam int NCFG    = 17;
    localparam int NFUNC   = 8;
    localparam int GF_HOLD = 2;

    typedef enum logic [PLANE_W-1:0] {
        PL_OWN     = 5'd0,
        PL_OE      = 5'd1,
        PL_OUT     = 5'd2,
        PL_PU      = 5'd3,
        PL_PD      = 5'd4,
        PL_FN0     = 5'd5,
        PL_FN1     = 5'd6,
        PL_FN2     = 5'd7,
        PL_DRV0    = 5'd8,
        PL_DRV1    = 5'd9,
        PL_SLEW    = 5'd10,
        PL_SCHMITT = 5'd11,
        PL_GLITCH  = 5'd12,
        PL_EVT     = 5'd13,
        PL_IEN     = 5'd14,
        PL_MODE0   = 5'd15,
        PL_MODE1   = 5'd16,
        PL_FLAG    = 5'd17,
        PL_PIN     = 5'd18
    } plane_e;

    typedef enum logic [1:0] {
        OP_RW   = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_NONE = 2'd3
    } op_e;
endpackage

// File: rtl/gpio_plane_regs.sv
module gpio_plane_regs
    import gpio_plane_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [PLANE_W-1:0]         wr_plane,
    input  logic [1:0]                 wr_op,
    input  logic [NPIN-1:0]            wr_data,
    input  logic [NPIN-1:0]            hit,
    output logic [NCFG-1:0][NPIN-1:0]  cfg,
    output logic [NPIN-1:0]            flag
);
    typedef struct packed {
        logic [NCFG-1:0][NPIN-1:0] cfg;
        logic [NPIN-1:0]           flag;
    } regs_t;

    regs_t r_d, r_q;
    logic [NPIN-1:0] flag_clr;

    function automatic logic [NPIN-1:0] apply_op(input logic [NPIN-1:0] cur,
                                                 input logic [1:0] op,
                                                 input logic [NPIN-1:0] m);
        case (op)
            OP_RW:   return m;
            OP_SET:  return cur | m;
            OP_CLR:  return cur & ~m;
            default: return cur;
        endcase
    endfunction

    always_comb begin
        r_d = r_q;
        for (int p = 0; p < NCFG; p++) begin
            if (wr_en && wr_plane == PLANE_W'(p)) begin
                r_d.cfg[p] = apply_op(r_q.cfg[p], wr_op, wr_data);
            end
        end
        flag_clr  = (wr_en && wr_plane == PL_FLAG && wr_op == OP_CLR) ? wr_data : '0;
        r_d.flag  = (r_q.flag & ~flag_clr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cfg         <= '0;
            r_q.cfg[PL_OWN] <= '1;
            r_q.flag        <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg  = r_q.cfg;
    assign flag = r_q.flag;

    for (genvar p = 0; p < NCFG; p++) begin : g_plane_chk
        a_r1_set_merges: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_plane == PLANE_W'(p) && wr_op == OP_SET)
            |=> (cfg[p] == ($past(cfg[p]) | $past(wr_data))));
        a_r1_clr_masks: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_plane == PLANE_W'(p) && wr_op == OP_CLR)
            |=> (cfg[p] == ($past(cfg[p]) & ~$past(wr_data))));
    end

    a_r11_flag_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag & ~$past(flag) & ~$past(hit)) == '0));
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync
    import gpio_plane_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pad_i,
    input  logic [NPIN-1:0] glitch_en,
    input  logic [NPIN-1:0] mode0,
    input  logic [NPIN-1:0] mode1,
    input  logic [NPIN-1:0] evt_en,
    input  logic [NPIN-1:0] own,
    output logic [NPIN-1:0] pin_lvl,
    output logic [NPIN-1:0] hit,
    output logic [NPIN-1:0] evt
);
    localparam int CNT_W = $clog2(GF_HOLD + 1);

    typedef struct packed {
        logic [NPIN-1:0]            s1;
        logic [NPIN-1:0]            s2;
        logic [NPIN-1:0]            lvl;
        logic [NPIN-1:0][CNT_W-1:0] cnt;
        logic [NPIN-1:0]            evt;
    } sync_t;

    sync_t st_d, st_q;
    logic [NPIN-1:0] chg, rise, fall;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pad_i;
        st_d.s2 = st_q.s1;
        for (int i = 0; i < NPIN; i++) begin
            if (!glitch_en[i]) begin
                st_d.lvl[i] = st_q.s2[i];
                st_d.cnt[i] = '0;
            end else if (st_q.s2[i] == st_q.lvl[i]) begin
                st_d.cnt[i] = '0;
            end else if (st_q.cnt[i] == CNT_W'(GF_HOLD)) begin
                st_d.lvl[i] = st_q.s2[i];
                st_d.cnt[i] = '0;
            end else begin
                st_d.cnt[i] = st_q.cnt[i] + 1'b1;
            end
        end
        chg  = st_d.lvl ^ st_q.lvl;
        rise = chg & st_d.lvl;
        fall = chg & ~st_d.lvl;
        for (int i = 0; i < NPIN; i++) begin
            case ({mode1[i], mode0[i]})
                2'b00:   hit[i] = chg[i];
                2'b01:   hit[i] = rise[i];
                2'b10:   hit[i] = fall[i];
                default: hit[i] = 1'b0;
            endcase
        end
        st_d.evt = hit & evt_en & ~own;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_lvl = st_q.s2;
    assign evt     = st_q.evt;

    for (genvar i = 0; i < NPIN; i++) begin : g_filt_chk
        a_r10_filter_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (glitch_en[i] && $past(glitch_en[i]) && st_q.lvl[i] != $past(st_q.lvl[i]))
            |-> ($past(st_q.s2[i], 1) == st_q.lvl[i] &&
                 $past(st_q.s2[i], 2) == st_q.lvl[i] &&
                 $past(st_q.s2[i], 3) == st_q.lvl[i]));
    end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_plane_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic [NPIN-1:0]             own,
    input  logic [NPIN-1:0]             oe,
    input  logic [NPIN-1:0]             outv,
    input  logic [NPIN-1:0]             fn0,
    input  logic [NPIN-1:0]             fn1,
    input  logic [NPIN-1:0]             fn2,
    input  logic [NFUNC-1:0][NPIN-1:0]  p_out,
    input  logic [NFUNC-1:0][NPIN-1:0]  p_oe,
    output logic [NPIN-1:0]             pad_o,
    output logic [NPIN-1:0]             pad_oe
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic [2:0] code;
        assign code      = {fn2[i], fn1[i], fn0[i]};
        assign pad_o[i]  = own[i] ? outv[i] : p_out[code][i];
        assign pad_oe[i] = own[i] ? oe[i]   : p_oe[code][i];
    end
endmodule

// File: rtl/gpio_plane_ctrl.sv
module gpio_plane_ctrl
    import gpio_plane_pkg::*;
#(
    parameter int NPIN   = 32,
    parameter int ADDR_W = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_sel,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [NPIN-1:0]        bus_wdata,
    output logic [NPIN-1:0]        bus_rdata,
    input  logic [NPIN-1:0]        pad_i,
    output logic [NPIN-1:0]        pad_o,
    output logic [NPIN-1:0]        pad_oe,
    output logic [NPIN-1:0]        pad_pu,
    output logic [NPIN-1:0]        pad_pd,
    output logic [NPIN-1:0]        pad_slew,
    output logic [NPIN-1:0]        pad_schmitt,
    output logic [2*NPIN-1:0]      pad_drv,
    input  logic [NFUNC*NPIN-1:0]  periph_o,
    input  logic [NFUNC*NPIN-1:0]  periph_oe,
    output logic [NPIN-1:0]        evt_o,
    output logic                   irq_o
);
    logic [PLANE_W-1:0]         acc_plane;
    logic [1:0]                 acc_op;
    logic [NCFG-1:0][NPIN-1:0]  cfg;
    logic [NPIN-1:0]            flag, hit, pin_lvl;
    logic [NFUNC-1:0][NPIN-1:0] pw_o, pw_oe;

    assign acc_plane = bus_addr[ADDR_W-1:2];
    assign acc_op    = bus_addr[1:0];
    assign pw_o      = periph_o;
    assign pw_oe     = periph_oe;

    gpio_plane_regs #(.NPIN(NPIN)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_sel && bus_wr),
        .wr_plane (acc_plane),
        .wr_op    (acc_op),
        .wr_data  (bus_wdata),
        .hit      (hit),
        .cfg      (cfg),
        .flag     (flag)
    );

    gpio_pin_sync #(.NPIN(NPIN)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pad_i     (pad_i),
        .glitch_en (cfg[PL_GLITCH]),
        .mode0     (cfg[PL_MODE0]),
        .mode1     (cfg[PL_MODE1]),
        .evt_en    (cfg[PL_EVT]),
        .own       (cfg[PL_OWN]),
        .pin_lvl   (pin_lvl),
        .hit       (hit),
        .evt       (evt_o)
    );

    gpio_pad_mux #(.NPIN(NPIN)) u_mux (
        .own    (cfg[PL_OWN]),
        .oe     (cfg[PL_OE]),
        .outv   (cfg[PL_OUT]),
        .fn0    (cfg[PL_FN0]),
        .fn1    (cfg[PL_FN1]),
        .fn2    (cfg[PL_FN2]),
        .p_out  (pw_o),
        .p_oe   (pw_oe),
        .pad_o  (pad_o),
        .pad_oe (pad_oe)
    );

    always_comb begin
        bus_rdata = '0;
        if (acc_op != OP_NONE) begin
            for (int p = 0; p < NCFG; p++) begin
                if (acc_plane == PLANE_W'(p)) bus_rdata = cfg[p];
            end
            if (acc_plane == PL_FLAG) bus_rdata = flag;
            if (acc_plane == PL_PIN)  bus_rdata = pin_lvl;
        end
    end

    assign pad_pu      = cfg[PL_PU];
    assign pad_pd      = cfg[PL_PD];
    assign pad_slew    = cfg[PL_SLEW];
    assign pad_schmitt = cfg[PL_SCHMITT];
    assign irq_o       = |(flag & cfg[PL_IEN]);

    for (genvar i = 0; i < NPIN; i++) begin : g_drv
        assign pad_drv[2*i +: 2] = {cfg[PL_DRV1][i], cfg[PL_DRV0][i]};
    end

    a_r2_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg[PL_OWN] == '1 && cfg[PL_OE] == '0 && flag == '0));

    a_r3_gpio_tristate: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg[PL_OWN] & ~cfg[PL_OE] & pad_oe) == '0));

    for (genvar i = 0; i < NPIN; i++) begin : g_pin_chk
        a_r9_reserved_mode: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[i]) |-> !($past(cfg[PL_MODE1][i]) && $past(cfg[PL_MODE0][i])));
        a_r12_evt_owner: assert property (@(posedge clk) disable iff (!rst_n)
            evt_o[i] |-> ($past(!cfg[PL_OWN][i]) && $past(cfg[PL_EVT][i])));
    end
endmodule

// File: tb/sim_gpio_plane_ctrl.sv
module sim_gpio_plane_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0, bus_wr = 1'b0;
    logic [6:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [31:0]  pad_i = '0;
    logic [31:0]  pad_o, pad_oe, pad_pu, pad_pd, pad_slew, pad_schmitt, evt_o;
    logic [63:0]  pad_drv;
    logic [255:0] periph_o, periph_oe;
    logic         irq_o;
    int           n_tests = 0, n_fail = 0;

    always #10 clk = ~clk;

    gpio_plane_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .pad_pd(pad_pd), .pad_slew(pad_slew), .pad_schmitt(pad_schmitt),
        .pad_drv(pad_drv), .periph_o(periph_o), .periph_oe(periph_oe),
        .evt_o(evt_o), .irq_o(irq_o)
    );

    typedef struct packed {
        logic [4:0]  pl;
        logic [1:0]  op;
        logic [31:0] wd;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{5'd2,  2'd0, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
        '{5'd2,  2'd1, 32'h0000_F0F0, 32'hA5A5_FFFF},
        '{5'd2,  2'd2, 32'hA5A5_0000, 32'h0000_FFFF},
        '{5'd2,  2'd0, 32'h0000_0000, 32'h0000_0000},
        '{5'd14, 2'd1, 32'h0000_0003, 32'h0000_0003},
        '{5'd14, 2'd2, 32'h0000_0001, 32'h0000_0002},
        '{5'd14, 2'd0, 32'h0000_0000, 32'h0000_0000},
        '{5'd17, 2'd0, 32'hFFFF_FFFF, 32'h0000_0000},
        '{5'd17, 2'd1, 32'hFFFF_FFFF, 32'h0000_0000},
        '{5'd0,  2'd2, 32'h0000_FF00, 32'hFFFF_00FF},
        '{5'd0,  2'd1, 32'h0000_FF00, 32'hFFFF_FFFF}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int pl, input int op, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1;
        bus_addr = {5'(pl), 2'(op)}; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int pl, input int op, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0;
        bus_addr = {5'(pl), 2'(op)};
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        periph_o  = '0;
        periph_o[6*32 + 7] = 1'b1;
        periph_oe = '1;
        periph_oe[3*32 +: 32] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        rd(0, 0, v);  chk("R2 own", v, 32'hFFFF_FFFF);
        rd(1, 0, v);  chk("R2 oe", v, 0);
        rd(7, 0, v);  chk("R2 fn2", v, 0);
        rd(16, 0, v); chk("R2 mode1", v, 0);
        rd(17, 0, v); chk("R2 flags", v, 0);
        chk("R2 pad_oe", pad_oe, 0);
        chk("R2 drive", pad_drv, 0);
        chk("R2 irq", irq_o, 0);

        // R1 / R11 plane access vectors
        for (int k = 0; k < NVEC; k++) begin
            wr(VECS[k].pl, VECS[k].op, VECS[k].wd);
            rd(VECS[k].pl, 0, v);
            chk($sformatf("R1/R11 vec %0d", k), v, VECS[k].exp);
        end
        wr(1, 3, 32'hFFFF_FFFF);
        rd(1, 0, v); chk("R1 slot3 write ignored", v, 0);
        wr(2, 0, 32'h1234_5678);
        rd(2, 3, v); chk("R1 slot3 reads zero", v, 0);
        wr(2, 0, 0);

        // R7 pin value latency and ignored writes
        @(negedge clk); pad_i = 32'hDEAD_0000;
        rd(18, 0, v); chk("R7 before sync", v, 0);
        rd(18, 0, v); chk("R7 after sync", v, 32'hDEAD_0000);
        wr(18, 0, 0);
        rd(18, 0, v); chk("R7 write ignored", v, 32'hDEAD_0000);
        repeat (3) @(negedge clk);
        wr(17, 2, 32'hFFFF_FFFF);
        rd(17, 0, v); chk("R11 flag clear slot", v, 0);

        // R3 GPIO drive / tri-state
        wr(2, 1, 32'h1);
        @(negedge clk); chk("R3 oe off tristate", pad_oe[0], 0);
        wr(1, 1, 32'h1);
        @(negedge clk); chk("R3 gpio drives", {pad_oe[0], pad_o[0]}, 2'b11);

        // R4 function select on pin 7
        wr(0, 2, 32'h80);
        wr(6, 1, 32'h80); wr(7, 1, 32'h80);
        @(negedge clk); chk("R4 fn6", {pad_oe[7], pad_o[7]}, 2'b11);
        wr(5, 1, 32'h80);
        @(negedge clk); chk("R4 fn7", {pad_oe[7], pad_o[7]}, 2'b10);
        wr(7, 2, 32'h80);
        @(negedge clk); chk("R4 fn3", {pad_oe[7], pad_o[7]}, 2'b00);

        // R5 drive code, R6 pad controls
        wr(8, 1, 32'h200); wr(9, 1, 32'h600);
        @(negedge clk); chk("R5 drive", pad_drv[21:18], 4'b1011);
        wr(3, 1, 32'h4); wr(4, 1, 32'h8); wr(10, 1, 32'h10); wr(11, 1, 32'h20);
        @(negedge clk);
        chk("R6 pads", {pad_pu[2], pad_pd[3], pad_slew[4], pad_schmitt[5]}, 4'hF);

        // R8 rising-only on pin 0 with exact latency, R11 irq
        wr(15, 1, 32'h1); wr(14, 1, 32'h1);
        @(negedge clk); pad_i[0] = 1'b1;
        @(negedge clk);
        rd(17, 0, v); chk("R8 not yet at k+1", v[0], 0);
        rd(17, 0, v); chk("R8 rise flag at k+2", v[0], 1);
        chk("R11 irq raised", irq_o, 1);
        wr(17, 2, 32'h1);
        @(negedge clk); chk("R11 irq cleared", irq_o, 0);
        pad_i[0] = 1'b0;
        repeat (5) @(negedge clk);
        rd(17, 0, v); chk("R8 rise mode ignores fall", v[0], 0);

        // R8 falling-only on pin 1, any-change on pin 2
        wr(16, 1, 32'h2);
        @(negedge clk); pad_i[1] = 1'b1; pad_i[2] = 1'b1;
        repeat (5) @(negedge clk);
        rd(17, 0, v); chk("R8 fall mode/any mode on rise", v[2:1], 2'b10);
        wr(17, 2, 32'h6);
        pad_i[1] = 1'b0; pad_i[2] = 1'b0;
        repeat (5) @(negedge clk);
        rd(17, 0, v); chk("R8 fall mode/any mode on fall", v[2:1], 2'b11);
        chk("R11 flag without enable no irq", irq_o, 0);
        wr(17, 2, 32'h6);

        // R9 reserved mode on pin 5
        wr(15, 1, 32'h20); wr(16, 1, 32'h20);
        @(negedge clk); pad_i[5] = 1'b1;
        repeat (5) @(negedge clk); pad_i[5] = 1'b0;
        repeat (5) @(negedge clk);
        rd(17, 0, v); chk("R9 mode 11 silent", v[5], 0);

        // R10 glitch filter on pin 4
        wr(12, 1, 32'h10);
        @(negedge clk); pad_i[4] = 1'b1;
        repeat (2) @(negedge clk); pad_i[4] = 1'b0;
        repeat (6) @(negedge clk);
        rd(17, 0, v); chk("R10 short pulse rejected", v[4], 0);
        pad_i[4] = 1'b1;
        repeat (3) @(negedge clk);
        rd(17, 0, v); chk("R10 not yet at k+3", v[4], 0);
        rd(17, 0, v); chk("R10 accepted at k+4", v[4], 1);
        pad_i[4] = 1'b0;

        // R12 event pulse on peripheral pin 8, none on GPIO pin 9
        wr(0, 2, 32'h100); wr(13, 1, 32'h300);
        @(negedge clk); pad_i[8] = 1'b1; pad_i[9] = 1'b1;
        @(negedge clk); chk("R12 no early event", evt_o[8], 0);
        @(negedge clk); chk("R12 no early event 2", evt_o[8], 0);
        @(negedge clk); chk("R12 event pulse", evt_o[9:8], 2'b01);
        @(negedge clk); chk("R12 one cycle only", evt_o[9:8], 2'b00);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule